// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block sits between a 16-bit CPU bus and the memory behind it. Every CPU access arrives through a valid/ready handshake. The block decodes the access to one of five targets: on-chip RAM, on-chip ROM, external RAM, external ROM, or a paged window into a wider extended memory. It then runs the access with the wait states and data width programmed for that target. It drives the chip selects and read/write strobes, splits 16-bit transfers into two byte beats for 8-bit devices, and returns read data together with a single-cycle ready pulse.

Three small control registers set the timing, and a separate configuration port writes them:
- The external timing register holds a width bit and a wait count for each external region.
- The internal control register holds the on-chip extra-wait bits, a ROM-merge option and an address-echo debug switch.
- The page register supplies the upper external address bits for the paged window.

The block copies the settings at the start of each access. A write to a control register therefore never disturbs an access that is already running.

Top module: `memwait_ctrl`

## Requirements
- R1: The CPU byte address is decoded by its bits 15:13, and the matching select is asserted for the whole access:
  - 0 selects on-chip RAM (`int_ram_cs`).
  - 1 to 3 select external RAM (`ext_ram_cs`).
  - 4 selects the paged extended window (`ext_xm_cs`).
  - 5 and 6 select external ROM (`ext_rom_cs`).
  - 7 selects on-chip ROM (`int_rom_cs`).
  - For the external RAM and ROM regions, `ext_addr` is the CPU address zero-extended to 22 bits.
- R2: The external timing register is configuration address 1. It holds 3-bit wait counts in bits 2:0 (RAM), 6:4 (ROM) and 10:8 (extended). For a 16-bit external access with N waits, the read or write strobe is high for N+1 cycles, and `cpu_ready` is high N+2 clock edges after `cpu_valid` is first sampled.
- R3: Width bits 3 (RAM), 7 (ROM) and 11 (extended) select 8-bit operation when set. A 16-bit transfer then runs as two beats of N+1 strobe cycles each, so ready comes 2N+3 edges after valid. Both beats use data lane 7:0. The first beat carries the even address and the low byte, the second the odd address and the high byte.
- R4: After reset, the registers read back as follows:
  - External timing register: 0x0777 (all waits 7, all widths 16).
  - Internal control register (configuration address 0): 0x0003.
  - Page register (configuration address 2): zero.
  - No select or strobe is active and `ext_addr` is zero.
- R5: In the internal control register, bit 0 adds one wait to on-chip RAM accesses and bit 1 adds one wait to on-chip ROM accesses. An on-chip access completes X+2 edges after valid, where X is its extra-wait bit. It raises no external strobe and returns `int_rdata`.
- R6: When internal control bit 3 is set, `ext_rom_cs` is asserted whenever `ext_xm_cs` is asserted. When the bit is clear, `ext_rom_cs` stays low during extended-window accesses.
- R7: When internal control bit 2 is set, `ext_addr` shows the CPU address during on-chip accesses. When it is clear, `ext_addr` stays zero during on-chip accesses.
- R8: Extended-window accesses drive `ext_addr` with page register bits 8:0 as address bits 21:13, above CPU address bits 12:0.
- R9: A configuration write made while an access is running does not change that access's timing. It applies from the next access.
- R10: `cpu_ready` is high for exactly one cycle per transfer, and `cpu_rdata` holds the assembled read data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | CPU access request, held until ready |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address (even) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with ready |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Register select: 0 internal, 1 external timing, 2 page |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read-back of the selected register |
| ext_addr | output | 22 | External byte address |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_oe | output | 1 | External read strobe |
| ext_we | output | 1 | External write strobe |
| ext_ram_cs | output | 1 | External RAM select |
| ext_rom_cs | output | 1 | External ROM select |
| ext_xm_cs | output | 1 | Extended window select |
| int_ram_cs | output | 1 | On-chip RAM select |
| int_rom_cs | output | 1 | On-chip ROM select |
| int_rdata | input | 16 | On-chip memory read data |

## Verification
The ready pulse is due at one of three points, counted in clock edges after valid is first sampled:
- N+2 for a 16-bit external access;
- 2N+3 for a split byte access;
- X+2 for an on-chip access.

The bench counts edges one at a time at falling edges until ready appears, and compares that count with the vector's expected latency. It samples strobes, selects, address and write data at every falling edge inside the access. It then checks the strobe-cycle total, the first-beat and last-beat address and data, and the read data captured in the ready cycle. A configuration write injected partway through an access tests that the running access keeps its own latency and that the following access picks up the new one.

// File: rtl/memwait_pkg.sv
// Shared constants and types for the memory wait-state controller.
// Assumes a 16-bit CPU byte address space and a 22-bit external address.
package memwait_pkg;
    localparam int ADDR_W  = 16;              // CPU address width
    localparam int DATA_W  = 16;              // CPU data width
    localparam int BYTE_W  = DATA_W / 2;      // byte lane width
    localparam int WIN_W   = 13;              // offset bits inside one window
    localparam int PAGE_W  = 9;               // page bits above the window
    localparam int XADDR_W = WIN_W + PAGE_W;  // external address width
    localparam int WAIT_W  = 3;               // wait-count field width
    localparam int N_XRGN  = 3;               // external regions
    localparam int FLD_W   = WAIT_W + 1;      // width bit plus wait count
    localparam int CFG_A_W = 2;               // configuration address width

    typedef enum logic [2:0] {
        RG_IRAM,
        RG_IROM,
        RG_XRAM,
        RG_XROM,
        RG_XMEM
    } region_e;

    typedef struct packed {
        logic              byte8;  // 1 = 8-bit device
        logic [WAIT_W-1:0] waits;  // wait states per beat
    } rgn_cfg_t;

    typedef struct packed {
        rgn_cfg_t [N_XRGN-1:0] ext;       // index 0 RAM, 1 ROM, 2 extended
        logic                  iram_wait; // extra wait for on-chip RAM
        logic                  irom_wait; // extra wait for on-chip ROM
        logic                  dbg;       // echo internal addresses
        logic                  merge;     // ROM select follows extended select
        logic [PAGE_W-1:0]     page;      // window upper address bits
    } cfg_t;
endpackage

// File: rtl/memwait_regs.sv
// Configuration registers of the wait-state controller.
// Holds the internal control bits, per-region external timing and the window
// page. Writes land on the clock edge; reads are combinational.
module memwait_regs
    import memwait_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_A_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    output cfg_t               cfg_o
);
    localparam int EXT_W = N_XRGN * FLD_W;
    localparam logic [EXT_W-1:0] EXT_RST = {N_XRGN{1'b0, {WAIT_W{1'b1}}}};
    localparam logic [3:0]       INT_RST = 4'b0011;

    logic [3:0]        int_q;
    logic [EXT_W-1:0]  ext_q;
    logic [PAGE_W-1:0] page_q;

    // Register update on configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= INT_RST;
            ext_q  <= EXT_RST;
            page_q <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                2'd0:    int_q  <= cfg_wdata[3:0];
                2'd1:    ext_q  <= cfg_wdata[EXT_W-1:0];
                2'd2:    page_q <= cfg_wdata[PAGE_W-1:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            2'd0:    cfg_rdata[3:0]        = int_q;
            2'd1:    cfg_rdata[EXT_W-1:0]  = ext_q;
            2'd2:    cfg_rdata[PAGE_W-1:0] = page_q;
            default: cfg_rdata = '0;
        endcase
    end

    // One timing field per external region.
    for (genvar g = 0; g < N_XRGN; g++) begin : g_rgn
        assign cfg_o.ext[g].byte8 = ext_q[g*FLD_W + WAIT_W];
        assign cfg_o.ext[g].waits = ext_q[g*FLD_W +: WAIT_W];
    end

    assign cfg_o.iram_wait = int_q[0];
    assign cfg_o.irom_wait = int_q[1];
    assign cfg_o.dbg       = int_q[2];
    assign cfg_o.merge     = int_q[3];
    assign cfg_o.page      = page_q;

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ext_q == EXT_RST && int_q == INT_RST && page_q == '0)); // R4
endmodule

// File: rtl/memwait_decode.sv
// Address decoder: maps CPU address bits 15:13 to a region and forms the
// external address, adding the page bits for the extended window.
module memwait_decode
    import memwait_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [PAGE_W-1:0]  page_i,
    output region_e            region_o,
    output logic [XADDR_W-1:0] xaddr_o
);
    localparam int SEL_W = ADDR_W - WIN_W;

    logic [SEL_W-1:0] win;
    assign win = addr_i[ADDR_W-1:WIN_W];

    // Region lookup from the window number.
    always_comb begin
        case (win)
            3'd0:       region_o = RG_IRAM;
            3'd4:       region_o = RG_XMEM;
            3'd5, 3'd6: region_o = RG_XROM;
            3'd7:       region_o = RG_IROM;
            default:    region_o = RG_XRAM;
        endcase
    end

    // External address: paged for the window, zero-extended elsewhere.
    always_comb begin
        if (region_o == RG_XMEM)
            xaddr_o = {page_i, addr_i[WIN_W-1:0]};
        else
            xaddr_o = {{(XADDR_W-ADDR_W){1'b0}}, addr_i};
    end
endmodule

// File: rtl/memwait_seq.sv
// Access sequencer: copies the settings at the start of an access, counts
// wait states per beat, splits 16-bit transfers into two byte beats for
// 8-bit regions, and drives strobes, selects and the CPU ready pulse.
// Assumes cpu_valid is held until cpu_ready and addresses are even.
module memwait_seq
    import memwait_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    input  logic               cpu_wr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  region_e            region_i,
    input  logic [XADDR_W-1:0] xaddr_i,
    input  cfg_t               cfg_i,
    input  logic [DATA_W-1:0]  ext_din,
    input  logic [DATA_W-1:0]  int_rdata,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic [XADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_oe,
    output logic               ext_we,
    output logic               ext_ram_cs,
    output logic               ext_rom_cs,
    output logic               ext_xm_cs,
    output logic               int_ram_cs,
    output logic               int_rom_cs
);
    typedef enum logic [1:0] {S_IDLE, S_ACC, S_DONE} state_e;

    state_e             st_q;
    region_e            rgn_q;
    logic [XADDR_W-1:0] addr_q;
    logic               wr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [WAIT_W-1:0]  cnt_q;
    logic [WAIT_W-1:0]  waits_q;
    logic               byte8_q;
    logic               beat_q;
    logic               dbg_q;
    logic               merge_q;

    logic [WAIT_W-1:0]  ld_waits;
    logic               ld_byte8;
    logic               acc;
    logic               is_ext;

    // Settings that apply to the region being entered.
    always_comb begin
        ld_waits = '0;
        ld_byte8 = 1'b0;
        case (region_i)
            RG_XRAM: begin ld_waits = cfg_i.ext[0].waits; ld_byte8 = cfg_i.ext[0].byte8; end
            RG_XROM: begin ld_waits = cfg_i.ext[1].waits; ld_byte8 = cfg_i.ext[1].byte8; end
            RG_XMEM: begin ld_waits = cfg_i.ext[2].waits; ld_byte8 = cfg_i.ext[2].byte8; end
            RG_IRAM: ld_waits = {{(WAIT_W-1){1'b0}}, cfg_i.iram_wait};
            RG_IROM: ld_waits = {{(WAIT_W-1){1'b0}}, cfg_i.irom_wait};
            default: ;
        endcase
    end

    // Access state machine with per-beat wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            rgn_q   <= RG_IRAM;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            cnt_q   <= '0;
            waits_q <= '0;
            byte8_q <= 1'b0;
            beat_q  <= 1'b0;
            dbg_q   <= 1'b0;
            merge_q <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (cpu_valid) begin
                    st_q    <= S_ACC;
                    rgn_q   <= region_i;
                    addr_q  <= xaddr_i;
                    wr_q    <= cpu_wr;
                    wdata_q <= cpu_wdata;
                    cnt_q   <= ld_waits;
                    waits_q <= ld_waits;
                    byte8_q <= ld_byte8;
                    beat_q  <= 1'b0;
                    dbg_q   <= cfg_i.dbg;
                    merge_q <= cfg_i.merge;
                end
                S_ACC: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (byte8_q && !beat_q) begin
                        rdata_q[BYTE_W-1:0] <= ext_din[BYTE_W-1:0];
                        beat_q <= 1'b1;
                        cnt_q  <= waits_q;
                    end else begin
                        if (byte8_q)
                            rdata_q[DATA_W-1:BYTE_W] <= ext_din[BYTE_W-1:0];
                        else if (is_ext)
                            rdata_q <= ext_din;
                        else
                            rdata_q <= int_rdata;
                        st_q <= S_DONE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign acc    = (st_q == S_ACC);
    assign is_ext = (rgn_q == RG_XRAM) || (rgn_q == RG_XROM) || (rgn_q == RG_XMEM);

    // Strobes and selects for the active access.
    always_comb begin
        ext_oe     = acc && is_ext && !wr_q;
        ext_we     = acc && is_ext && wr_q;
        ext_ram_cs = acc && (rgn_q == RG_XRAM);
        ext_xm_cs  = acc && (rgn_q == RG_XMEM);
        ext_rom_cs = acc && ((rgn_q == RG_XROM) || (merge_q && rgn_q == RG_XMEM));
        int_ram_cs = acc && (rgn_q == RG_IRAM);
        int_rom_cs = acc && (rgn_q == RG_IROM);
    end

    // External address and write data, byte beats on the low lane.
    always_comb begin
        ext_addr = '0;
        ext_dout = '0;
        if (acc && is_ext) begin
            ext_addr = byte8_q ? {addr_q[XADDR_W-1:1], beat_q} : addr_q;
            if (wr_q) begin
                if (!byte8_q)
                    ext_dout = wdata_q;
                else if (beat_q)
                    ext_dout[BYTE_W-1:0] = wdata_q[DATA_W-1:BYTE_W];
                else
                    ext_dout[BYTE_W-1:0] = wdata_q[BYTE_W-1:0];
            end
        end else if (acc && dbg_q) begin
            ext_addr = addr_q;
        end
    end

    assign cpu_ready = (st_q == S_DONE);
    assign cpu_rdata = rdata_q;

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_oe && ext_we)); // R2
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_ram_cs, ext_xm_cs, int_ram_cs, int_rom_cs, ext_rom_cs && !ext_xm_cs})); // R1
    AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |=> $stable({waits_q, byte8_q, dbg_q, merge_q})); // R9
    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_q) |-> (byte8_q && ext_addr[0])); // R3
    AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ram_cs || int_rom_cs) |-> !(ext_oe || ext_we)); // R5
    AST_MERGE_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_xm_cs && merge_q) |-> ext_rom_cs); // R6
    AST_DBG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_ram_cs || int_rom_cs) && !dbg_q) |-> (ext_addr == '0)); // R7
endmodule

// File: rtl/memwait_ctrl.sv
// Top of the external memory wait-state controller. Connects the
// configuration registers, the address decoder and the access sequencer.
// Assumes one outstanding CPU access at a time.
module memwait_ctrl
    import memwait_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               cfg_wr,
    input  logic [CFG_A_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    output logic [XADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    input  logic [DATA_W-1:0]  ext_din,
    output logic               ext_oe,
    output logic               ext_we,
    output logic               ext_ram_cs,
    output logic               ext_rom_cs,
    output logic               ext_xm_cs,
    output logic               int_ram_cs,
    output logic               int_rom_cs,
    input  logic [DATA_W-1:0]  int_rdata
);
    cfg_t               cfg;
    region_e            region;
    logic [XADDR_W-1:0] xaddr;

    memwait_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_o     (cfg)
    );

    memwait_decode u_dec (
        .addr_i   (cpu_addr),
        .page_i   (cfg.page),
        .region_o (region),
        .xaddr_o  (xaddr)
    );

    memwait_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_valid  (cpu_valid),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .region_i   (region),
        .xaddr_i    (xaddr),
        .cfg_i      (cfg),
        .ext_din    (ext_din),
        .int_rdata  (int_rdata),
        .cpu_ready  (cpu_ready),
        .cpu_rdata  (cpu_rdata),
        .ext_addr   (ext_addr),
        .ext_dout   (ext_dout),
        .ext_oe     (ext_oe),
        .ext_we     (ext_we),
        .ext_ram_cs (ext_ram_cs),
        .ext_rom_cs (ext_rom_cs),
        .ext_xm_cs  (ext_xm_cs),
        .int_ram_cs (int_ram_cs),
        .int_rom_cs (int_rom_cs)
    );

    AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> $past(cpu_valid)); // R10
endmodule

// File: tb/sim_memwait_ctrl.sv
// Self-checking bench: vector table walk, then directed corner cases.
module sim_memwait_ctrl;
    import memwait_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cpu_valid = 1'b0, cpu_wr = 1'b0;
    logic [15:0]        cpu_addr = '0, cpu_wdata = '0;
    logic               cpu_ready;
    logic [15:0]        cpu_rdata;
    logic               cfg_wr = 1'b0;
    logic [1:0]         cfg_addr = '0;
    logic [15:0]        cfg_wdata = '0;
    logic [15:0]        cfg_rdata;
    logic [21:0]        ext_addr;
    logic [15:0]        ext_dout, ext_din, int_rdata;
    logic               ext_oe, ext_we, ext_ram_cs, ext_rom_cs, ext_xm_cs, int_ram_cs, int_rom_cs;

    assign ext_din   = {~ext_addr[7:0], ext_addr[7:0] ^ 8'h3C};
    assign int_rdata = {8'hC3, cpu_addr[7:0]};

    memwait_ctrl u0 (.*);

    int n_run = 0, n_fail = 0;

    // Results of the last access.
    int          r_lat, r_strb;
    logic [15:0] r_rdata, r_fdout, r_ldout;
    logic [21:0] r_faddr, r_laddr, r_iaddr;
    logic [4:0]  r_cs;
    logic        r_after;

    typedef struct packed {
        logic [15:0] ext;
        logic [3:0]  ictl;
        logic [8:0]  page;
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [7:0]  lat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 4'h0, 9'h000, 1'b0, 16'h2000, 16'h0000, 8'd2},
        '{16'h0003, 4'h0, 9'h000, 1'b0, 16'h4A10, 16'h0000, 8'd5},
        '{16'h0050, 4'h0, 9'h000, 1'b0, 16'hA124, 16'h0000, 8'd7},
        '{16'h0080, 4'h0, 9'h000, 1'b0, 16'hC010, 16'h0000, 8'd3},
        '{16'h0A00, 4'h0, 9'h155, 1'b0, 16'h8ABC, 16'h0000, 8'd7},
        '{16'h0700, 4'h0, 9'h001, 1'b1, 16'h9FFE, 16'h1234, 8'd9},
        '{16'h000C, 4'h0, 9'h000, 1'b1, 16'h6000, 16'hA55A, 8'd11},
        '{16'h0000, 4'h1, 9'h000, 1'b0, 16'h0100, 16'h0000, 8'd3},
        '{16'h0000, 4'h0, 9'h000, 1'b0, 16'h0200, 16'h0000, 8'd2},
        '{16'h0000, 4'h2, 9'h000, 1'b0, 16'hE000, 16'h0000, 8'd3},
        '{16'h0000, 4'h1, 9'h000, 1'b0, 16'hF000, 16'h0000, 8'd2},
        '{16'h0777, 4'h0, 9'h000, 1'b0, 16'h3000, 16'h0000, 8'd9}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // One CPU access; optional timing-register write at edge count mid_at.
    task automatic run_access(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                              input int mid_at, input logic [15:0] mid_ext);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        r_lat = 0; r_strb = 0; r_cs = '0; r_iaddr = '0;
        r_faddr = '0; r_laddr = '0; r_fdout = '0; r_ldout = '0; r_rdata = '0;
        forever begin
            @(negedge clk);
            r_lat++;
            cfg_wr = 1'b0;
            if (r_lat == mid_at) begin
                cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = mid_ext;
            end
            if (ext_oe || ext_we) begin
                if (r_strb == 0) begin r_faddr = ext_addr; r_fdout = ext_dout; end
                r_laddr = ext_addr; r_ldout = ext_dout;
                r_strb++;
            end
            r_cs |= {ext_ram_cs, ext_rom_cs, ext_xm_cs, int_ram_cs, int_rom_cs};
            if (int_ram_cs || int_rom_cs) r_iaddr |= ext_addr;
            if (cpu_ready) begin r_rdata = cpu_rdata; break; end
            if (r_lat > 64) break;
        end
        cpu_valid = 1'b0; cfg_wr = 1'b0;
        @(negedge clk);
        r_after = cpu_ready;
    endtask

    function automatic logic [21:0] exp_xaddr(input logic [15:0] a, input logic [8:0] pg);
        return (a[15:13] == 3'd4) ? {pg, a[12:0]} : {6'b0, a};
    endfunction

    function automatic logic [4:0] exp_cs(input logic [15:0] a);
        case (a[15:13])
            3'd0:       return 5'b00010;
            3'd4:       return 5'b00100;
            3'd5, 3'd6: return 5'b01000;
            3'd7:       return 5'b00001;
            default:    return 5'b10000;
        endcase
    endfunction

    function automatic logic is_byte8(input logic [15:0] a, input logic [15:0] ext);
        case (a[15:13])
            3'd0, 3'd7: return 1'b0;
            3'd4:       return ext[11];
            3'd5, 3'd6: return ext[7];
            default:    return ext[3];
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state at the ports and through read-back.
        check(!cpu_ready && !ext_oe && !ext_we && ext_addr == 0 &&
              !ext_ram_cs && !ext_rom_cs && !ext_xm_cs && !int_ram_cs && !int_rom_cs,
              "R4", "idle outputs", {31'b0, cpu_ready}, 0);
        cfg_read(2'd1, d); check(d == 16'h0777, "R4", "timing reset", d, 16'h0777);
        cfg_read(2'd0, d); check(d == 16'h0003, "R4", "internal reset", d, 16'h0003);
        cfg_read(2'd2, d); check(d == 16'h0000, "R4", "page reset", d, 0);
        run_access(1'b0, 16'h2000, 16'h0, 0, 16'h0);
        check(r_lat == 9, "R4", "default 7-wait latency", r_lat, 9);
        run_access(1'b0, 16'h0400, 16'h0, 0, 16'h0);
        check(r_lat == 3, "R4", "default on-chip extra wait", r_lat, 3);

        // Vector table walk.
        foreach (VEC[i]) begin
            logic        b8, intl;
            logic [21:0] xa;
            logic [15:0] er;
            string       tg;
            cfg_write(2'd1, VEC[i].ext);
            cfg_write(2'd0, {12'b0, VEC[i].ictl});
            cfg_write(2'd2, {7'b0, VEC[i].page});
            run_access(VEC[i].wr, VEC[i].addr, VEC[i].wd, 0, 16'h0);
            b8   = is_byte8(VEC[i].addr, VEC[i].ext);
            intl = (VEC[i].addr[15:13] == 3'd0) || (VEC[i].addr[15:13] == 3'd7);
            xa   = exp_xaddr(VEC[i].addr, VEC[i].page);
            tg   = intl ? "R5" : (b8 ? "R3" : "R2");
            check(r_lat == int'(VEC[i].lat), tg, "latency", r_lat, VEC[i].lat);
            check(r_strb == (intl ? 0 : int'(VEC[i].lat) - 1), tg, "strobe cycles",
                  r_strb, intl ? 0 : VEC[i].lat - 1);
            check(r_cs == exp_cs(VEC[i].addr), "R1", "selects", r_cs, exp_cs(VEC[i].addr));
            check(r_after == 1'b0, "R10", "ready single cycle", r_after, 0);
            if (!intl) begin
                check(r_faddr == xa, (VEC[i].addr[15:13] == 3'd4) ? "R8" : "R1",
                      "first address", r_faddr, xa);
                check(r_laddr == (b8 ? (xa | 22'd1) : xa), "R3", "last address",
                      r_laddr, b8 ? (xa | 22'd1) : xa);
            end
            if (VEC[i].wr) begin
                check(r_fdout == (b8 ? {8'h0, VEC[i].wd[7:0]} : VEC[i].wd), "R3",
                      "first write data", r_fdout, b8 ? {8'h0, VEC[i].wd[7:0]} : VEC[i].wd);
                check(r_ldout == (b8 ? {8'h0, VEC[i].wd[15:8]} : VEC[i].wd), "R3",
                      "last write data", r_ldout, b8 ? {8'h0, VEC[i].wd[15:8]} : VEC[i].wd);
            end else begin
                if (intl)    er = {8'hC3, VEC[i].addr[7:0]};
                else if (b8) er = {(xa[7:0] | 8'h01) ^ 8'h3C, xa[7:0] ^ 8'h3C};
                else         er = {~xa[7:0], xa[7:0] ^ 8'h3C};
                check(r_rdata == er, b8 ? "R3" : "R10", "read data", r_rdata, er);
            end
        end

        // R6: ROM merge on and off during extended accesses.
        cfg_write(2'd1, 16'h0000);
        cfg_write(2'd0, 16'h0008);
        run_access(1'b0, 16'h8000, 16'h0, 0, 16'h0);
        check(r_cs == 5'b01100, "R6", "merge on selects", r_cs, 5'b01100);
        cfg_write(2'd0, 16'h0000);
        run_access(1'b0, 16'h8000, 16'h0, 0, 16'h0);
        check(r_cs == 5'b00100, "R6", "merge off selects", r_cs, 5'b00100);

        // R7: address echo during on-chip accesses.
        cfg_write(2'd0, 16'h0004);
        run_access(1'b0, 16'h0246, 16'h0, 0, 16'h0);
        check(r_iaddr == 22'h000246, "R7", "debug echo", r_iaddr, 22'h000246);
        cfg_write(2'd0, 16'h0000);
        run_access(1'b0, 16'hE246, 16'h0, 0, 16'h0);
        check(r_iaddr == 22'h0, "R7", "no echo", r_iaddr, 0);

        // R9: mid-access timing write applies only to the next access.
        cfg_write(2'd1, 16'h0006);
        run_access(1'b0, 16'h2000, 16'h0, 2, 16'h0000);
        check(r_lat == 8, "R9", "running access keeps waits", r_lat, 8);
        run_access(1'b0, 16'h2000, 16'h0, 0, 16'h0);
        check(r_lat == 2, "R9", "next access uses new waits", r_lat, 2);

        // R8: page bits at the top of the window range.
        cfg_write(2'd2, 16'h01FF);
        run_access(1'b0, 16'h9FFE, 16'h0, 0, 16'h0);
        check(r_faddr == 22'h3FFFFE, "R8", "page all ones", r_faddr, 22'h3FFFFE);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule